// File: doc/BRIEF.md
# DMA Channel Stall Watchdog

This block sits beside one DMA channel and times the gaps between the channel's internal bus accesses. Each access is signalled by a one-cycle strobe. While stall detection is enabled, an idle counter runs from the most recent strobe. If the gap reaches the programmed interval before the next strobe arrives, a sticky stall flag is raised.

The stall is a non-fatal error. The watchdog only observes the channel and never stops it, so the channel keeps moving data whenever it wins the bus. An error interrupt request follows the flag, gated by an enable. Software acknowledges the stall by pulsing a clear input, and that clear is also what arms the watchdog again. A 3-bit interval code selects the timeout. Code zero turns detection off.

Top module: `dma_stall_watchdog`

## Requirements
- R1: While `rst` is high at a clock edge, `stall_flag_o` and `err_irq_o` are 0 after that edge.
- R2: For a nonzero interval code N, the interval is 2^(N+7) cycles: 256 for code 1, doubling per step, up to 16384 for code 7. If the access strobe is sampled at edge E and no strobe or clear is sampled later, the flag is 0 after edge E+2^(N+7)-1 and 1 after edge E+2^(N+7).
- R3: An access strobe sampled at any edge restarts the idle count from zero, including the edge at which the interval would have expired. At that edge the flag stays 0.
- R4: Interval code 0 disables detection. The flag never sets, however long the channel is idle, and the idle count is held at zero, so a later nonzero code starts timing from zero.
- R5: Once set, the flag stays 1 through access strobes, code changes and enable changes until a clear is sampled.
- R6: A clear sampled at edge C makes the flag 0 after C and re-arms detection. With no strobe after C, the flag sets again after edge C+interval.
- R7: If a clear and an expiring interval fall on the same edge, the clear wins. The flag is 0 after that edge and counting restarts from zero.
- R8: `err_irq_o` is a registered level. After each edge it equals the flag after that edge ANDed with `err_irq_en_i` as sampled at that edge. It drops one edge after the enable falls or with the clear.
- R9: With `err_irq_en_i` held at 0, `err_irq_o` stays 0 even when the flag is set.
- R10: Shortening the interval code while the idle count already meets the new interval sets the flag at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_access_i | input | 1 | One-cycle strobe for each internal bus access by the channel |
| interval_code_i | input | CODE_W (3) | Stall interval code; 0 disables detection |
| err_irq_en_i | input | 1 | Error interrupt enable |
| stall_clr_i | input | 1 | Software clear of the stall flag; re-arms detection |
| stall_flag_o | output | 1 | Sticky stall status flag |
| err_irq_o | output | 1 | Error interrupt request, level |

## Verification
The bound checker watches several rules on every cycle. It confirms that the flag is sticky and that a clear always wins. It confirms that an access strobe or a zero code can never raise the flag, and that the interrupt tracks the flag and the previous cycle's enable. It also keeps its own idle counter, which rules out a flag earlier than the shortest interval. The exact expiry cycle for each code, the restart after a strobe in the last cycle, the re-arming after a clear and the effect of shortening the code mid-count depend on counts that run into the thousands. Only the bench's timed scenarios can show those.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

  // Idle-counter width: large enough to hold the longest interval minus one
  // (2^(2^code_w - 1 + base_shift) - 1), plus a spare bit for comparisons.
  function automatic int unsigned cnt_width(input int unsigned code_w,
                                            input int unsigned base_shift);
    return (1 << code_w) - 1 + base_shift + 1;
  endfunction

  // Highest usable code for a given code width.
  function automatic int unsigned max_code(input int unsigned code_w);
    return (1 << code_w) - 1;
  endfunction

endpackage

// File: rtl/dsw_interval_decode.sv
module dsw_interval_decode #(
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned BASE_SHIFT = 7,
  parameter int unsigned CNT_W      = 15
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              enabled_o,
  output logic [CNT_W-1:0]  limit_m1_o
);

  localparam int unsigned NUM_CODES = 1 << CODE_W;

  logic [CNT_W-1:0] limit_tab [NUM_CODES];

  // One entry per code; code 0 is the disabled slot and carries no limit.
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_tab
    if (g == 0) begin : g_off
      assign limit_tab[g] = '0;
    end else begin : g_on
      assign limit_tab[g] = CNT_W'((64'd1 << (g + BASE_SHIFT)) - 64'd1);
    end
  end

  assign enabled_o  = (code_i != '0);
  assign limit_m1_o = limit_tab[code_i];

endmodule

// File: rtl/dsw_idle_counter.sv
module dsw_idle_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             hold_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_o <= '0;
    end else if (!hold_i && cnt_o != CNT_MAX) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/dsw_flag_irq.sv
module dsw_flag_irq (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic hit_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);

  logic flag_d;

  // Clear takes priority over a new hit arriving on the same edge.
  always_comb begin
    if (clr_i) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_o | hit_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_o <= flag_d;
      irq_o  <= flag_d & irq_en_i;
    end
  end

endmodule

// File: rtl/dma_stall_watchdog.sv
module dma_stall_watchdog #(
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned BASE_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_access_i,
  input  logic [CODE_W-1:0] interval_code_i,
  input  logic              err_irq_en_i,
  input  logic              stall_clr_i,
  output logic              stall_flag_o,
  output logic              err_irq_o
);

  localparam int unsigned CNT_W = dsw_pkg::cnt_width(CODE_W, BASE_SHIFT);

  logic             det_enabled;
  logic [CNT_W-1:0] limit_m1;
  logic [CNT_W-1:0] idle_cnt;
  logic             cnt_restart;
  logic             stall_hit;
  logic             flag_q;

  dsw_interval_decode #(
    .CODE_W    (CODE_W),
    .BASE_SHIFT(BASE_SHIFT),
    .CNT_W     (CNT_W)
  ) u_decode (
    .code_i    (interval_code_i),
    .enabled_o (det_enabled),
    .limit_m1_o(limit_m1)
  );

  assign cnt_restart = bus_access_i | stall_clr_i | ~det_enabled;

  dsw_idle_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk      (clk),
    .rst      (rst),
    .restart_i(cnt_restart),
    .hold_i   (flag_q),
    .cnt_o    (idle_cnt)
  );

  // An access in the final cycle counts as on time; >= covers a shortened code.
  assign stall_hit = det_enabled & ~flag_q & ~bus_access_i & ~stall_clr_i &
                     (idle_cnt >= limit_m1);

  dsw_flag_irq u_flag (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (stall_clr_i),
    .hit_i   (stall_hit),
    .irq_en_i(err_irq_en_i),
    .flag_o  (flag_q),
    .irq_o   (err_irq_o)
  );

  assign stall_flag_o = flag_q;

endmodule

// File: rtl/dsw_checker.sv
module dsw_checker #(
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned BASE_SHIFT = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_access_i,
  input logic [CODE_W-1:0] interval_code_i,
  input logic              err_irq_en_i,
  input logic              stall_clr_i,
  input logic              stall_flag_o,
  input logic              err_irq_o
);

  localparam int unsigned MIN_LIMIT = 1 << (BASE_SHIFT + 1);

  // Independent gap tracker, saturating, used for the minimum-interval check.
  logic [31:0] gap;
  always_ff @(posedge clk) begin
    if (rst || bus_access_i || stall_clr_i || stall_flag_o ||
        interval_code_i == '0) begin
      gap <= '0;
    end else if (gap != 32'hFFFF_FFFF) begin
      gap <= gap + 1;
    end
  end

  p_min_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (!stall_flag_o && gap < MIN_LIMIT - 1) |=> !stall_flag_o);

  p_access_no_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (!stall_flag_o && bus_access_i) |=> !stall_flag_o);

  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (!stall_flag_o && interval_code_i == '0) |=> !stall_flag_o);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (stall_flag_o && !stall_clr_i) |=> stall_flag_o);

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
    stall_clr_i |=> !stall_flag_o);

  p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_irq_o == (stall_flag_o && $past(err_irq_en_i))));

  p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    !err_irq_en_i |=> !err_irq_o);

endmodule

bind dma_stall_watchdog dsw_checker #(
  .CODE_W    (CODE_W),
  .BASE_SHIFT(BASE_SHIFT)
) u_dsw_checker (
  .clk            (clk),
  .rst            (rst),
  .bus_access_i   (bus_access_i),
  .interval_code_i(interval_code_i),
  .err_irq_en_i   (err_irq_en_i),
  .stall_clr_i    (stall_clr_i),
  .stall_flag_o   (stall_flag_o),
  .err_irq_o      (err_irq_o)
);

// File: tb/dma_stall_watchdog_test.sv
module dma_stall_watchdog_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc = 1'b0;
  logic [2:0] code = 3'd0;
  logic       en = 1'b0;
  logic       clr = 1'b0;
  logic       flag;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_stall_watchdog uut (
    .clk            (clk),
    .rst            (rst),
    .bus_access_i   (acc),
    .interval_code_i(code),
    .err_irq_en_i   (en),
    .stall_clr_i    (clr),
    .stall_flag_o   (flag),
    .err_irq_o      (irq)
  );

  // {code[19:17], irq enable[16], interval in cycles[15:0]}
  localparam logic [19:0] VEC [7] = '{
    {3'd1, 1'b1, 16'd256},
    {3'd2, 1'b0, 16'd512},
    {3'd3, 1'b1, 16'd1024},
    {3'd4, 1'b0, 16'd2048},
    {3'd5, 1'b1, 16'd4096},
    {3'd6, 1'b0, 16'd8192},
    {3'd7, 1'b1, 16'd16384}
  };

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Clear and strobe together for one cycle: count is zero after that edge.
  task automatic restart(input logic [2:0] c, input logic e);
    @(negedge clk);
    clr = 1'b1; acc = 1'b1; code = c; en = e;
    @(negedge clk);
    clr = 1'b0; acc = 1'b0;
  endtask

  initial begin
    wait_n(200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    wait_n(3);
    chk("R1", "flag in reset", flag, 1'b0);
    chk("R1", "irq in reset", irq, 1'b0);
    rst = 1'b0;

    // R2 / R8 / R9: table of codes, enables and expected intervals
    for (int i = 0; i < 7; i++) begin
      restart(VEC[i][19:17], VEC[i][16]);
      wait_n(int'(VEC[i][15:0]) - 1);
      chk("R2", $sformatf("flag one cycle early, code %0d", VEC[i][19:17]), flag, 1'b0);
      wait_n(1);
      chk("R2", $sformatf("flag at interval, code %0d", VEC[i][19:17]), flag, 1'b1);
      chk(VEC[i][16] ? "R8" : "R9", $sformatf("irq, code %0d", VEC[i][19:17]),
          irq, VEC[i][16]);
    end

    // R3: strobe at the expiring edge restarts the count
    restart(3'd1, 1'b1);
    wait_n(255);
    acc = 1'b1;
    wait_n(1);
    acc = 1'b0;
    chk("R3", "strobe on last cycle", flag, 1'b0);
    wait_n(255);
    chk("R3", "restarted count early", flag, 1'b0);
    wait_n(1);
    chk("R3", "restarted count expiry", flag, 1'b1);

    // R4: code 0 never stalls
    restart(3'd0, 1'b1);
    wait_n(600);
    chk("R4", "flag with code 0", flag, 1'b0);
    chk("R4", "irq with code 0", irq, 1'b0);
    // R4: code 0 holds the count at zero
    restart(3'd1, 1'b1);
    wait_n(200);
    code = 3'd0;
    wait_n(1);
    code = 3'd1;
    wait_n(255);
    chk("R4", "count reset by code 0", flag, 1'b0);
    wait_n(1);
    chk("R4", "full interval after code 0", flag, 1'b1);

    // R5: sticky through strobes, code and enable changes
    acc = 1'b1; wait_n(1); acc = 1'b0;
    code = 3'd0; en = 1'b0;
    wait_n(3);
    chk("R5", "flag stays set", flag, 1'b1);

    // R8: irq follows enable one edge later
    code = 3'd1; en = 1'b1;
    wait_n(1);
    chk("R8", "irq after enable rises", irq, 1'b1);
    en = 1'b0;
    wait_n(1);
    chk("R8", "irq after enable falls", irq, 1'b0);
    chk("R8", "flag unaffected by enable", flag, 1'b1);
    en = 1'b1;
    wait_n(1);

    // R6: clear drops flag and irq, then a full interval from the clear
    clr = 1'b1;
    wait_n(1);
    clr = 1'b0;
    chk("R6", "flag after clear", flag, 1'b0);
    chk("R6", "irq after clear", irq, 1'b0);
    wait_n(255);
    chk("R6", "re-armed early", flag, 1'b0);
    wait_n(1);
    chk("R6", "re-armed expiry", flag, 1'b1);

    // R7: clear on the expiring edge wins
    restart(3'd1, 1'b1);
    wait_n(255);
    clr = 1'b1;
    wait_n(1);
    clr = 1'b0;
    chk("R7", "clear beats stall", flag, 1'b0);
    wait_n(255);
    chk("R7", "count restarted early", flag, 1'b0);
    wait_n(1);
    chk("R7", "count restarted expiry", flag, 1'b1);

    // R10: shortening the code mid-count
    restart(3'd3, 1'b1);
    wait_n(600);
    chk("R10", "before code change", flag, 1'b0);
    code = 3'd1;
    wait_n(1);
    chk("R10", "after shorter code", flag, 1'b1);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule